// File: doc/BRIEF.md
# ADC I2C Slave Responder

This block is a two-wire serial slave that stands in for a small two-channel analog-to-digital converter. It lets a bus master controller be exercised against realistic target behaviour. Both bus lines are brought into the system clock domain and edge-detected there. A state machine then follows the bus: it takes the address byte, accepts register bytes in a write, and in a read returns a 10-bit sample from a parallel input port as two bytes.

The slave answers only at the fixed 7-bit address `0110110`. In a write, each data byte is sorted by its top bit: a byte with the top bit set goes to the setup register, and a byte with the top bit clear goes to the configuration register. In a read, the sample is captured once, when the address byte is accepted. The first byte carries six zero bits followed by sample bits 9:8. The second byte carries sample bits 7:0. If the master keeps acknowledging, the pair repeats. A not-acknowledge from the master ends the data phase.

States: `ST_IDLE` (bus free), `ST_ADDR` (shifting the address byte), `ST_ADDR_ACK` (acknowledging the address), `ST_WR_BYTE` and `ST_WR_ACK` (receiving and acknowledging a register byte), `ST_RD_BYTE` and `ST_RD_ACK` (sending a byte and sampling the master's answer), and `ST_IGNORE` (hands off until the next bus condition).

Transitions:
- Any state moves to `ST_IDLE` on STOP, and to `ST_ADDR` on START.
- `ST_ADDR` moves to `ST_ADDR_ACK` on an address hit and to `ST_IGNORE` on a miss, at the SCL fall after the 8th bit.
- `ST_ADDR_ACK` moves to `ST_RD_BYTE` or `ST_WR_BYTE` according to the R/W bit, at the fall that ends the acknowledge clock.
- `ST_WR_BYTE` moves to `ST_WR_ACK` after 8 bits, and `ST_WR_ACK` returns to `ST_WR_BYTE`.
- `ST_RD_BYTE` moves to `ST_RD_ACK` after 8 bits.
- `ST_RD_ACK` moves to `ST_RD_BYTE` when the master acknowledged (0) and to `ST_IGNORE` when it did not (1).

Top module: `adc_i2c_responder`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are `0110110`; bit 0 of that byte selects write (0) or read (1). An address byte whose upper seven bits differ receives no acknowledge.
- R2: A START (SDA falling while SCL is high) returns the slave to address reception from any state, including a repeated START in the middle of a transaction. A STOP (SDA rising while SCL is high) returns it to idle.
- R3: The slave pulls SDA low for the whole 9th clock of every byte it accepts (address or written byte), and keeps SDA released during the eight clocks in which the master sends.
- R4: A written byte with bit 7 = 1 is stored in `setup_reg`. A written byte with bit 7 = 0 is stored in `config_reg`. The other register keeps its value.
- R5: Read data goes out MSB first. The first byte is `{6'b0, sample[9:8]}` and the second byte is `sample[7:0]`. While the master acknowledges, the two bytes repeat in that order.
- R6: The slave changes its SDA drive only while SCL is low, except at a START or STOP. Each read bit is therefore stable throughout SCL high.
- R7: After the master answers a read byte with NACK (1), the slave no longer drives SDA until the next START or STOP.
- R8: `sample_in` is captured when the read address is accepted. Later changes of `sample_in` do not alter the bytes of that transaction.
- R9: After an address mismatch, the slave never drives SDA and stores no byte until the next START.
- R10: `bus_err` pulses for one cycle when a START or STOP arrives after two or more clocks of a byte being shifted. A clean repeated START or STOP does not raise it.
- R11: `xfer_done` pulses for one cycle on a STOP that ends a transaction in which the address matched. There is no pulse after a mismatched address.
- R12: Out of reset, `sda_pull`, `bus_err` and `xfer_done` are 0, and `setup_reg` and `config_reg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| sample_in | input | 10 | Conversion result served in reads |
| sda_pull | output | 1 | When 1, the data line is driven low (open-drain enable) |
| setup_reg | output | 8 | Last written byte with bit 7 set |
| config_reg | output | 8 | Last written byte with bit 7 clear |
| bus_err | output | 1 | One-cycle pulse: START or STOP arrived inside a byte |
| xfer_done | output | 1 | One-cycle pulse: an addressed transaction ended with STOP |

## Verification
A wrong state in this machine shows up on the bus within one byte time. A lost bit count moves or removes the acknowledge, which the master sees as a NACK at the 9th clock. A wrong write/read branch either drives data into a write or leaves a read line floating high. A wrong byte pointer or shift order returns bytes that differ from the expected padded sample at the very first read. A missed START or STOP shows at once, as a missing `xfer_done` pulse or as a slave that stays silent after a repeated START.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } resp_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings both bus lines into the clock domain and flags edges and bus conditions.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Idle bus is high on both lines, so reset to 1 to avoid false conditions.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        scl_lvl   = scl_pipe[STAGES-1];
        sda_lvl   = sda_pipe[STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/i2c_resp_fsm.sv
// Byte-level protocol engine of the converter responder.
module i2c_resp_fsm
    import adc_resp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0110110,
    parameter int         SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_lvl,
    input  logic                sda_lvl,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                sda_pull,
    output logic [7:0]          setup_reg,
    output logic [7:0]          config_reg,
    output logic                bus_err,
    output logic                xfer_done
);

    localparam int                WORD_W   = 2 * BYTE_BITS;
    localparam int                PAD_W    = WORD_W - SAMPLE_W;
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0]  ERR_MIN  = CNT_W'(2);

    resp_state_e           state, state_n;
    logic [CNT_W-1:0]      bit_cnt;
    logic [7:0]            rx_q;
    logic [7:0]            tx_q;
    logic [SAMPLE_W-1:0]   sample_q;
    logic                  lo_next_q;
    logic                  ack_q;
    logic                  addressed_q;
    logic [7:0]            setup_q;
    logic [7:0]            config_q;
    logic                  bus_err_q;
    logic                  done_q;
    logic                  addr_hit;
    logic                  in_byte;
    logic                  byte_end;
    logic [WORD_W-1:0]     word;

    always_comb begin
        addr_hit = (rx_q[7:1] == DEV_ADDR);
        in_byte  = (state == ST_ADDR) || (state == ST_WR_BYTE) || (state == ST_RD_BYTE);
        byte_end = scl_fall && (bit_cnt == LAST_BIT);
        word     = {{PAD_W{1'b0}}, sample_q};
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (byte_end) state_n = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_n = rx_q[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) state_n = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_n = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) state_n = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_n = ack_q ? ST_RD_BYTE : ST_IGNORE;
                ST_IGNORE:   state_n = ST_IGNORE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Bit counter, shifters, stored registers and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            rx_q        <= '0;
            tx_q        <= '1;
            sample_q    <= '0;
            lo_next_q   <= 1'b0;
            ack_q       <= 1'b0;
            addressed_q <= 1'b0;
            setup_q     <= '0;
            config_q    <= '0;
            bus_err_q   <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            bus_err_q <= (start_det || stop_det) && in_byte && (bit_cnt >= ERR_MIN);
            done_q    <= stop_det && addressed_q;
            if (start_det || stop_det) begin
                bit_cnt     <= '0;
                addressed_q <= 1'b0;
            end else begin
                if (scl_rise) begin
                    if (in_byte && (bit_cnt < LAST_BIT))
                        bit_cnt <= bit_cnt + 1'b1;
                    if (((state == ST_ADDR) || (state == ST_WR_BYTE)) && (bit_cnt < LAST_BIT))
                        rx_q <= {rx_q[6:0], sda_lvl};
                    if (state == ST_RD_ACK)
                        ack_q <= ~sda_lvl;
                end
                if (scl_fall) begin
                    if ((state == ST_ADDR) && (bit_cnt == LAST_BIT) && addr_hit) begin
                        addressed_q <= 1'b1;
                        if (rx_q[0]) sample_q <= sample_in;
                    end
                    if ((state == ST_ADDR_ACK) || (state == ST_WR_ACK) || (state == ST_RD_ACK))
                        bit_cnt <= '0;
                    if (state == ST_ADDR_ACK) begin
                        tx_q      <= word[WORD_W-1:BYTE_BITS];
                        lo_next_q <= 1'b1;
                    end
                    if ((state == ST_WR_BYTE) && (bit_cnt == LAST_BIT)) begin
                        if (rx_q[7]) setup_q  <= rx_q;
                        else         config_q <= rx_q;
                    end
                    if ((state == ST_RD_BYTE) && (bit_cnt < LAST_BIT))
                        tx_q <= {tx_q[6:0], 1'b1};
                    if ((state == ST_RD_ACK) && ack_q) begin
                        tx_q      <= lo_next_q ? word[BYTE_BITS-1:0] : word[WORD_W-1:BYTE_BITS];
                        lo_next_q <= ~lo_next_q;
                    end
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sda_pull   = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                     ((state == ST_RD_BYTE) && !tx_q[7]);
        setup_reg  = setup_q;
        config_reg = config_q;
        bus_err    = bus_err_q;
        xfer_done  = done_q;
    end

    AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(start_det || stop_det)) |-> !scl_lvl); // R6

    AST_ACK_AFTER_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_ACK && $past(state) == ST_WR_BYTE) |-> $past(bit_cnt) == LAST_BIT); // R3

    AST_SETUP_MSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(setup_q) |-> setup_q[7]); // R4

    AST_CONFIG_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(config_q) |-> !config_q[7]); // R4

    AST_SAMPLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RD_BYTE || state == ST_RD_ACK) &&
         $past(state == ST_RD_BYTE || state == ST_RD_ACK)) |-> $stable(sample_q)); // R8

    AST_ERR_ON_CONDITION: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (state == ST_ADDR || state == ST_IDLE)); // R10

    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> state == ST_IDLE); // R11

endmodule

// File: rtl/adc_i2c_responder.sv
module adc_i2c_responder #(
    parameter logic [6:0] DEV_ADDR    = 7'b0110110,
    parameter int         SAMPLE_W    = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                sda_pull,
    output logic [7:0]          setup_reg,
    output logic [7:0]          config_reg,
    output logic                bus_err,
    output logic                xfer_done
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_line_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_resp_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .SAMPLE_W (SAMPLE_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl    (scl_lvl),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sample_in  (sample_in),
        .sda_pull   (sda_pull),
        .setup_reg  (setup_reg),
        .config_reg (config_reg),
        .bus_err    (bus_err),
        .xfer_done  (xfer_done)
    );

endmodule

// File: tb/test_adc_i2c_responder.sv
module test_adc_i2c_responder;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [9:0] sample = '0;
    logic       sda_line;
    logic       sda_pull, bus_err, xfer_done;
    logic [7:0] setup_reg, config_reg;

    assign sda_line = sda_m & ~sda_pull;

    adc_i2c_responder i_adc_i2c_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sample_in  (sample),
        .sda_pull   (sda_pull),
        .setup_reg  (setup_reg),
        .config_reg (config_reg),
        .bus_err    (bus_err),
        .xfer_done  (xfer_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   done_cnt = 0;
    int   err_cnt  = 0;
    logic pull_any = 1'b0;
    logic finished = 1'b0;

    always @(negedge clk) begin
        if (xfer_done) done_cnt++;
        if (bus_err)   err_cnt++;
        if (sda_pull)  pull_any = 1'b1;
    end

    // Scoreboard: expected read bytes queued by the driver, compared as they arrive.
    typedef struct { string req; logic [7:0] val; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] obs_q[$];

    always @(negedge clk) begin
        while (obs_q.size() > 0 && exp_q.size() > 0) begin
            exp_t       e;
            logic [7:0] o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            n_tests++;
            if (o !== e.val) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", e.req, o, e.val);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; idle(HALF/2);
        scl_m = 1'b1; idle(HALF);
        sda_m = 1'b0; idle(HALF);
        scl_m = 1'b0; idle(HALF/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(HALF/2);
        scl_m = 1'b1; idle(HALF);
        sda_m = 1'b1; idle(HALF);
    endtask

    task automatic send_bit(input logic b, inout logic quiet);
        sda_m = b; idle(HALF/2);
        scl_m = 1'b1; idle(HALF/2);
        if (sda_pull) quiet = 1'b0;
        idle(HALF/2);
        scl_m = 1'b0; idle(HALF/2);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack, output logic quiet);
        quiet = 1'b1;
        for (int i = 7; i >= 0; i--) send_bit(b[i], quiet);
        sda_m = 1'b1; idle(HALF/2);
        scl_m = 1'b1; idle(HALF/2);
        ack = sda_line;
        idle(HALF/2);
        scl_m = 1'b0; idle(HALF/2);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] v, output logic stable);
        logic b1, b2;
        v = '0;
        stable = 1'b1;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            idle(HALF/2);
            scl_m = 1'b1; idle(3);
            b1 = sda_line; idle(HALF-6);
            b2 = sda_line;
            if (b1 !== b2) stable = 1'b0;
            v = {v[6:0], b1};
            idle(3);
            scl_m = 1'b0;
        end
        idle(HALF/4);
        sda_m = nack; idle(HALF/4);
        scl_m = 1'b1; idle(HALF);
        scl_m = 1'b0; idle(HALF/2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic       ack, q, st;
        logic [7:0] v;
        int         d0, e0;

        idle(5);
        // R12 reset state
        check("R12 sda_pull in reset", sda_pull, 0);
        check("R12 setup_reg in reset", setup_reg, 0);
        check("R12 config_reg in reset", config_reg, 0);
        check("R12 pulses in reset", {bus_err, xfer_done}, 0);
        rst_n = 1'b1;
        idle(10);

        // Write transaction: address, setup byte, configuration byte
        bus_start();
        write_byte(8'h6C, ack, q);
        check("R1 write address acknowledged", ack, 0);
        check("R3 released during address bits", q, 1);
        write_byte(8'hD2, ack, q);
        check("R3 setup byte acknowledged", ack, 0);
        check("R3 released during data bits", q, 1);
        check("R4 MSB=1 byte to setup_reg", setup_reg, 8'hD2);
        write_byte(8'h61, ack, q);
        check("R4 MSB=0 byte to config_reg", config_reg, 8'h61);
        check("R4 setup_reg kept", setup_reg, 8'hD2);
        d0 = done_cnt;
        bus_stop();
        idle(5);
        check("R11 done pulse after addressed STOP", done_cnt, d0 + 1);

        // Mismatched address: silent until next START
        pull_any = 1'b0;
        bus_start();
        write_byte(8'h6E, ack, q);
        check("R1 wrong address not acknowledged", ack, 1);
        write_byte(8'h85, ack, q);
        check("R9 byte after mismatch not acknowledged", ack, 1);
        check("R9 setup_reg unchanged after mismatch", setup_reg, 8'hD2);
        check("R9 no drive after mismatch", pull_any, 0);
        d0 = done_cnt;
        bus_stop();
        idle(5);
        check("R11 no done pulse after mismatch", done_cnt, d0);

        // Read transaction with sample change after address accept
        sample = 10'h2A5;
        bus_start();
        write_byte(8'h6D, ack, q);
        check("R1 read address acknowledged", ack, 0);
        sample = 10'h15A;
        exp_q.push_back('{"R5 first byte padded", 8'h02});
        read_byte(1'b0, v, st);
        obs_q.push_back(v);
        check("R6 read bits stable while SCL high", st, 1);
        exp_q.push_back('{"R8 second byte from captured sample", 8'hA5});
        read_byte(1'b0, v, st);
        obs_q.push_back(v);
        exp_q.push_back('{"R5 pair repeats after ACK", 8'h02});
        read_byte(1'b1, v, st);
        obs_q.push_back(v);
        check("R6 repeated byte stable", st, 1);
        pull_any = 1'b0;
        exp_q.push_back('{"R7 line released after NACK", 8'hFF});
        read_byte(1'b1, v, st);
        obs_q.push_back(v);
        check("R7 no drive after NACK", pull_any, 0);
        d0 = done_cnt;
        bus_stop();
        idle(5);
        check("R11 done pulse after read", done_cnt, d0 + 1);

        // Repeated START from write into read
        bus_start();
        write_byte(8'h6C, ack, q);
        write_byte(8'h45, ack, q);
        check("R4 second config write", config_reg, 8'h45);
        e0 = err_cnt;
        bus_start();
        write_byte(8'h6D, ack, q);
        check("R2 address accepted after repeated START", ack, 0);
        exp_q.push_back('{"R2 read after repeated START", 8'h01});
        read_byte(1'b1, v, st);
        obs_q.push_back(v);
        bus_stop();
        idle(5);
        check("R10 no error on clean repeated START", err_cnt, e0);

        // Mismatch, then repeated START to a matching address
        bus_start();
        write_byte(8'h20, ack, q);
        check("R1 address 0x10 not acknowledged", ack, 1);
        bus_start();
        write_byte(8'h6C, ack, q);
        check("R2 START leaves ignore state", ack, 0);
        write_byte(8'hF0, ack, q);
        check("R4 setup write after recovery", setup_reg, 8'hF0);
        bus_stop();
        idle(5);

        // STOP in the middle of a byte
        bus_start();
        write_byte(8'h6C, ack, q);
        e0 = err_cnt;
        d0 = done_cnt;
        q = 1'b1;
        send_bit(1'b1, q);
        send_bit(1'b0, q);
        send_bit(1'b1, q);
        send_bit(1'b0, q);
        bus_stop();
        idle(5);
        check("R10 error pulse on STOP inside byte", err_cnt, e0 + 1);
        check("R10 partial byte not stored", config_reg, 8'h45);
        check("R11 done pulse on interrupted transfer", done_cnt, d0 + 1);
        check("R2 idle after STOP", sda_pull, 0);

        idle(20);
        check("R5 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule